// File: doc/BRIEF.md
# Windowed multi-pass sample accumulator

The block takes in a stream of unsigned samples that carries a valid flag and has no backpressure. It cuts each pass of the stream into fixed windows of `WIN_LEN` consecutive samples and adds each window into one bin. Bin k collects samples k*WIN_LEN through k*WIN_LEN+WIN_LEN-1 of a pass. The stream is sent several times (passes). Each pass adds its window sums into the same bins, so at the end every bin holds the total over all passes.

A one-cycle start pulse captures the per-pass sample count and the pass count. The sample count must be a positive multiple of `WIN_LEN`, and it gives at most `MAX_BINS` bins. The pass count runs from 1 to `MAX_PASSES`. The bins live in an internal memory that is updated by read-modify-write. The first pass writes its sums directly, so results left from an earlier operation never leak in.

When the last window of the last pass has been stored, the bins are offered in ascending order over a valid/ready port. A finish flag rises after the last bin has been taken.

Top module: `win_accum`

## Requirements
- R1: Within one pass, bin k equals the sum of samples k*WIN_LEN through k*WIN_LEN+WIN_LEN-1 of that pass.
- R2: With P passes (1 to MAX_PASSES), bin k equals the sum over all P passes of that pass's window-k sum.
- R3: Bin values are BIN_W bits wide and wrap modulo 2^BIN_W.
- R4: The sample count and the pass count are taken only on the cycle `start` is high. Changing them later has no effect on the results.
- R5: Each operation's results contain no contribution from data of any earlier operation.
- R6: A cycle with `s_valid` low is ignored, wherever it falls inside a pass or between passes. The block keeps its position in the window, the bin and the pass across such a gap.
- R7: Samples presented with `s_valid` high while no operation is running are ignored. This covers the time before the first start and the time after the last sample of the final pass.
- R8: Readout presents bins with `m_index` starting at 0 and rising by one per accepted transfer (`m_valid` and `m_ready` both high). While `m_valid` is high and `m_ready` is low, `m_data` and `m_index` stay unchanged.
- R9: Both `m_valid` and `finish` are low after reset. `m_valid` stays low until all passes are accumulated. `finish` rises the cycle after the final transfer and stays high until the next start, with `m_valid` low while `finish` is high.
- R10: The number of bins read out equals the sample count divided by WIN_LEN. `m_last` is high exactly with the bin whose index is that number minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an operation |
| smp_count | input | CNT_W | Samples per pass, a multiple of WIN_LEN |
| pass_count | input | PASS_W | Number of passes, 1 to MAX_PASSES |
| s_valid | input | 1 | Sample present this cycle |
| s_data | input | SAMPLE_W | Unsigned sample |
| m_valid | output | 1 | A bin is offered |
| m_ready | input | 1 | Consumer takes the offered bin |
| m_data | output | BIN_W | Bin total |
| m_index | output | IDX_W | Bin index |
| m_last | output | 1 | Offered bin is the final one |
| finish | output | 1 | All bins accumulated and handed off |

## Verification
Two events can coincide. The read-modify-write of one window's bin can overlap the first samples of the next pass, and the last window's write can race the first readout fetch. The bench sends passes back-to-back with no gap, so a pass's bin-0 update follows right after the previous pass's last-bin write. It also starts readout straight after the final sample while extra ignored samples are still arriving. Each bin is judged against a sum the bench computes from its own copy of the samples, under single-pass, many-pass, wrapping, gapped and stalled-readout patterns.

// File: rtl/win_accum_pkg.sv
package win_accum_pkg;
   typedef enum logic [1:0] {
      RD_IDLE,
      RD_FETCH,
      RD_HOLD,
      RD_DONE
   } rd_state_t;
endpackage

// File: rtl/bin_ram.sv
module bin_ram #(
   parameter int W     = 32,
   parameter int DEPTH = 4096,
   parameter int AW    = 12
) (
   input  logic          clk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
   end
endmodule

// File: rtl/win_sum.sv
module win_sum #(
   parameter int SAMPLE_W = 12,
   parameter int BIN_W    = 32,
   parameter int WIN_LEN  = 65,
   parameter int IDX_W    = 12,
   parameter int CNT_W    = 19,
   parameter int PASS_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [PASS_W-1:0] pass_in,
   input  logic              s_valid,
   input  logic [SAMPLE_W-1:0] s_data,
   output logic              upd_valid,
   output logic [IDX_W-1:0]  upd_idx,
   output logic [BIN_W-1:0]  upd_sum,
   output logic              upd_first,
   output logic              upd_last,
   output logic [IDX_W:0]    nbins,
   output logic              busy
);
   localparam int WPOS_W = $clog2(WIN_LEN);

   logic [CNT_W-1:0]  cnt_q, smp_pos;
   logic [PASS_W-1:0] pass_q, pass_idx;
   logic [WPOS_W-1:0] win_pos;
   logic [IDX_W-1:0]  bin_idx;
   logic [BIN_W-1:0]  acc, sum_nx;
   logic win_end, pass_end, last_pass, take;

   always_comb begin
      take      = busy && s_valid;
      win_end   = (win_pos == WPOS_W'(WIN_LEN - 1));
      pass_end  = (smp_pos == cnt_q - CNT_W'(1));
      last_pass = (pass_idx == pass_q - PASS_W'(1));
      sum_nx    = acc + BIN_W'(s_data);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; cnt_q <= '0; pass_q <= '0;
         smp_pos <= '0; pass_idx <= '0; win_pos <= '0; bin_idx <= '0;
         acc <= '0; nbins <= '0;
         upd_valid <= 1'b0; upd_idx <= '0; upd_sum <= '0;
         upd_first <= 1'b0; upd_last <= 1'b0;
      end else begin
         upd_valid <= 1'b0;
         if (start) begin
            busy <= 1'b1; cnt_q <= cnt_in; pass_q <= pass_in;
            smp_pos <= '0; pass_idx <= '0; win_pos <= '0; bin_idx <= '0;
            acc <= '0;
         end else if (take) begin
            upd_valid <= win_end;
            if (win_end) begin
               upd_idx   <= bin_idx;
               upd_sum   <= sum_nx;
               upd_first <= (pass_idx == '0);
               upd_last  <= pass_end && last_pass;
               acc       <= '0;
               win_pos   <= '0;
            end else begin
               acc     <= sum_nx;
               win_pos <= win_pos + WPOS_W'(1);
            end
            if (pass_end) begin
               smp_pos  <= '0;
               bin_idx  <= '0;
               pass_idx <= pass_idx + PASS_W'(1);
               nbins    <= {1'b0, bin_idx} + (IDX_W+1)'(1);
               if (last_pass) busy <= 1'b0;
            end else begin
               smp_pos <= smp_pos + CNT_W'(1);
               if (win_end) bin_idx <= bin_idx + IDX_W'(1);
            end
         end
      end
   end

   // R1: a window needs WIN_LEN samples, so updates never come on adjacent cycles
   p_upd_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> !upd_valid);
   // R7: no operation running means no bin update follows
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !upd_valid);
endmodule

// File: rtl/bin_reader.sv
module bin_reader
   import win_accum_pkg::*;
#(
   parameter int W     = 32,
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             go,
   input  logic [IDX_W:0]   nbins,
   output logic             ram_re,
   output logic [IDX_W-1:0] ram_addr,
   input  logic [W-1:0]     ram_rdata,
   output logic             m_valid,
   input  logic             m_ready,
   output logic [W-1:0]     m_data,
   output logic [IDX_W-1:0] m_index,
   output logic             m_last,
   output logic             finish
);
   rd_state_t        state;
   logic [IDX_W-1:0] idx;
   logic [IDX_W:0]   nb_q;
   logic             at_end;

   always_comb begin
      at_end   = ({1'b0, idx} == nb_q - (IDX_W+1)'(1));
      m_valid  = (state == RD_HOLD);
      m_data   = ram_rdata;
      m_index  = idx;
      m_last   = m_valid && at_end;
      ram_re   = (state == RD_FETCH);
      ram_addr = idx;
      finish   = (state == RD_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RD_IDLE; idx <= '0; nb_q <= '0;
      end else if (start) begin
         state <= RD_IDLE;
      end else begin
         case (state)
            RD_IDLE:  if (go) begin
                         nb_q  <= nbins;
                         idx   <= '0;
                         state <= RD_FETCH;
                      end
            RD_FETCH: state <= RD_HOLD;
            RD_HOLD:  if (m_ready) begin
                         if (at_end) state <= RD_DONE;
                         else begin
                            idx   <= idx + IDX_W'(1);
                            state <= RD_FETCH;
                         end
                      end
            default:  state <= state;
         endcase
      end
   end

   // R8: an offered bin is held until taken
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready && !start) |=> (m_valid && $stable(m_data) && $stable(m_index)));
   // R8: readout walks the bins upward one at a time
   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && !m_last && !start) |=> (m_index == $past(m_index) + IDX_W'(1)));
   // R9: finish only follows the final transfer
   p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(finish) |-> $past(m_valid && m_ready && m_last));
   // R9: never offering data once finished
   p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(finish && m_valid));
endmodule

// File: rtl/win_accum.sv
module win_accum #(
   parameter int SAMPLE_W   = 12,
   parameter int BIN_W      = 32,
   parameter int WIN_LEN    = 65,
   parameter int MAX_BINS   = 4096,
   parameter int MAX_PASSES = 64,
   localparam int IDX_W     = $clog2(MAX_BINS),
   localparam int CNT_W     = $clog2(MAX_BINS * WIN_LEN + 1),
   localparam int PASS_W    = $clog2(MAX_PASSES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CNT_W-1:0]    smp_count,
   input  logic [PASS_W-1:0]   pass_count,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_data,
   output logic                m_valid,
   input  logic                m_ready,
   output logic [BIN_W-1:0]    m_data,
   output logic [IDX_W-1:0]    m_index,
   output logic                m_last,
   output logic                finish
);
   if (WIN_LEN < 3) begin : g_bad_win
      initial $error("WIN_LEN must be at least 3 so bin updates cannot overlap");
   end
   if (MAX_PASSES < 1 || MAX_BINS < 2) begin : g_bad_size
      initial $error("MAX_PASSES must be positive and MAX_BINS at least 2");
   end

   logic              upd_valid, upd_first, upd_last, busy;
   logic [IDX_W-1:0]  upd_idx;
   logic [BIN_W-1:0]  upd_sum;
   logic [IDX_W:0]    nbins;

   logic              s1_v, s1_first, s1_last;
   logic [IDX_W-1:0]  s1_idx;
   logic [BIN_W-1:0]  s1_sum, wdata, rdata;
   logic              rd_re, ram_re, go;
   logic [IDX_W-1:0]  rd_addr, raddr;

   win_sum #(
      .SAMPLE_W(SAMPLE_W), .BIN_W(BIN_W), .WIN_LEN(WIN_LEN),
      .IDX_W(IDX_W), .CNT_W(CNT_W), .PASS_W(PASS_W)
   ) u_sum (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cnt_in(smp_count), .pass_in(pass_count),
      .s_valid(s_valid), .s_data(s_data),
      .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_sum(upd_sum),
      .upd_first(upd_first), .upd_last(upd_last),
      .nbins(nbins), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0;
         s1_idx <= '0; s1_sum <= '0;
      end else begin
         s1_v <= upd_valid;
         if (upd_valid) begin
            s1_idx   <= upd_idx;
            s1_sum   <= upd_sum;
            s1_first <= upd_first;
            s1_last  <= upd_last;
         end
      end
   end

   always_comb begin
      wdata  = s1_first ? s1_sum : (rdata + s1_sum);
      go     = s1_v && s1_last;
      raddr  = rd_re ? rd_addr : upd_idx;
      ram_re = upd_valid || rd_re;
   end

   bin_ram #(.W(BIN_W), .DEPTH(MAX_BINS), .AW(IDX_W)) u_ram (
      .clk(clk), .re(ram_re), .raddr(raddr), .rdata(rdata),
      .we(s1_v), .waddr(s1_idx), .wdata(wdata)
   );

   bin_reader #(.W(BIN_W), .IDX_W(IDX_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .start(start), .go(go), .nbins(nbins),
      .ram_re(rd_re), .ram_addr(rd_addr), .ram_rdata(rdata),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
      .m_index(m_index), .m_last(m_last), .finish(finish)
   );

   // R2: a bin being written is never the one being read for the next update
   p_no_rmw_clash_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v |-> !(upd_valid && upd_idx == s1_idx));
   // R9: nothing is offered while passes are still being accumulated
   p_no_early_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !m_valid);
endmodule

// File: tb/sim_win_accum.sv
module sim_win_accum;
   localparam int SW = 12, BW = 20, WL = 65, MB = 4096, MP = 64;
   localparam int IW = $clog2(MB);
   localparam int CW = $clog2(MB * WL + 1);
   localparam int PW = $clog2(MP + 1);
   localparam int MAXS = 8400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CW-1:0] smp_count = '0;
   logic [PW-1:0] pass_count = '0;
   logic s_valid = 1'b0;
   logic [SW-1:0] s_data = '0;
   logic m_valid, m_ready, m_last, finish;
   logic [BW-1:0] m_data;
   logic [IW-1:0] m_index;

   always #4 clk = ~clk;

   win_accum #(.SAMPLE_W(SW), .BIN_W(BW), .WIN_LEN(WL), .MAX_BINS(MB),
               .MAX_PASSES(MP)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .smp_count(smp_count),
      .pass_count(pass_count), .s_valid(s_valid), .s_data(s_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
      .m_index(m_index), .m_last(m_last), .finish(finish));

   int checks = 0, failures = 0;
   bit over = 0;
   logic [SW-1:0] smp [MAXS];

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint exp_bin(int k, int nb, int np);
      longint s = 0;
      for (int p = 0; p < np; p++)
         for (int j = 0; j < WL; j++)
            s += smp[p * nb * WL + k * WL + j];
      return s % (longint'(1) << BW);
   endfunction

   task automatic run_op(string tag, int nb, int np, int pat, int gaps, int stalls);
      int n = nb * WL * np;
      bit early = 0;
      logic [BW-1:0] held;
      for (int i = 0; i < n; i++)
         case (pat)
            0: smp[i] = SW'($urandom);
            1: smp[i] = {SW{1'b1}};
            default: smp[i] = SW'((i * 7 + 3) % 4096);
         endcase
      @(negedge clk);
      start = 1'b1; smp_count = CW'(nb * WL); pass_count = PW'(np);
      @(negedge clk);
      start = 1'b0; smp_count = CW'($urandom); pass_count = PW'($urandom); // R4
      for (int p = 0; p < np; p++) begin
         for (int i = 0; i < nb * WL; i++) begin
            if (gaps == 2 && $urandom % 4 == 0) begin
               s_valid = 1'b0; s_data = SW'($urandom);
               @(negedge clk);
               early |= m_valid;
            end
            s_valid = 1'b1; s_data = smp[p * nb * WL + i];
            @(negedge clk);
            early |= m_valid;
         end
         if (gaps >= 1) begin
            s_valid = 1'b0; s_data = SW'($urandom);
            repeat (1 + $urandom % 4) @(negedge clk);
         end
      end
      s_valid = 1'b1; s_data = {SW{1'b1}}; // R7 trailing samples
      repeat (2) @(negedge clk);
      s_valid = 1'b0;
      check("R9", "m_valid during accumulation", early, 0);
      for (int k = 0; k < nb; k++) begin
         int to = 0;
         while (!m_valid && to < 200) begin
            @(negedge clk); to++;
         end
         check("R8", "m_valid offered", m_valid, 1);
         if (stalls != 0 && $urandom % 2 == 0) begin
            held = m_data;
            @(negedge clk);
            check("R8", "hold valid", m_valid, 1);
            check("R8", "hold data", m_data, held);
         end
         check(tag, $sformatf("bin %0d value", k), m_data, exp_bin(k, nb, np));
         check("R8", "bin index", m_index, k);
         check("R10", "last flag", m_last, (k == nb - 1));
         m_ready = 1'b1;
         @(negedge clk);
         m_ready = 1'b0;
      end
      check("R9", "finish after final transfer", finish, 1);
      check("R9", "m_valid low when finished", m_valid, 0);
      @(negedge clk);
      check("R9", "finish held", finish, 1);
   endtask

   task automatic summary();
      if (!over) begin
         over = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 190000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed));
      m_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "m_valid after reset", m_valid, 0);
      check("R9", "finish after reset", finish, 0);
      s_valid = 1'b1; // R7: samples before any start
      for (int i = 0; i < 80; i++) begin
         s_data = SW'($urandom);
         @(negedge clk);
      end
      s_valid = 1'b0;
      check("R7", "no output from idle samples", m_valid, 0);
      run_op("R1", 1, 1, 2, 0, 0);
      run_op("R2", 3, 2, 0, 1, 0);
      run_op("R3", 4, 4, 1, 1, 1);
      run_op("R5", 4, 1, 2, 0, 0);
      run_op("R6", 5, 3, 0, 2, 1);
      run_op("R4", 2, 64, 0, 0, 1);
      for (int t = 0; t < 4; t++)
         run_op("R2", 1 + $urandom % 6, 1 + $urandom % 5, 0, $urandom % 3, 1);
      s_valid = 1'b1; // R7: samples after the operation finished
      repeat (70) @(negedge clk);
      s_valid = 1'b0;
      check("R7", "finish kept after idle samples", finish, 1);
      check("R7", "no output from idle samples", m_valid, 0);
      summary();
   end
endmodule